// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block chooses, once per reset, whether a small microcontroller core comes up in normal user mode or in a serial debug monitor mode. While reset is held low it samples the high-voltage indications, a pin-configuration-valid flag, a clock divisor select pin and the two bytes of the reset vector. The values present at the clock edge just before reset releases become the latched mode. An erased vector (both bytes reading all ones) forces monitor mode. Otherwise, monitor mode needs a high voltage on the interrupt pin together with a valid pin configuration.

In monitor mode the block handles the opening handshake. It counts security bytes arriving from a byte-wide receive interface. After the eighth byte it holds the serial transmit line low for ten bit times, which form a break the host can also use to measure the baud rate. It then raises a ready-for-command flag. For as long as monitor mode lasts, it holds off the watchdog as the entry kind requires and moves vector fetches from the top page to the page below it.

Top module: `monitor_entry_ctrl`

## Requirements
- R1: The mode and its entry kind are taken from the inputs sampled at the last clock edge before `rst_n` rises. Changes to those inputs after release have no effect on `monitor_o` or `div_sel_o` until the next reset.
- R2: The vector counts as blank only when `vec_hi_i` and `vec_lo_i` both equal 8'hFF. `monitor_o` is 1 when the vector is blank, or when `hv_irq_i` and `pin_cfg_ok_i` were both 1; otherwise it is 0.
- R3: After a blank-vector entry, `wdt_run_o` is 0 whatever the live levels of `hv_irq_i`, `hv_rst_i` and `wdt_en_i`.
- R4: After a high-voltage entry with a non-blank vector, `wdt_run_o` equals `wdt_en_i` AND NOT (`hv_irq_i` OR `hv_rst_i`), using the live levels.
- R5: `div_sel_o` carries the latched divisor select only when monitor mode was entered with `hv_irq_i` and `pin_cfg_ok_i` both 1. In every other case it is 0, so a blank-only entry ignores the pin configuration.
- R6: In monitor mode, `tx_o` stays 1 and `cmd_ready_o` stays 0 until exactly eight cycles with `rx_valid_i`=1 have been seen after release.
- R7: `tx_o` goes to 0 in the cycle after the eighth byte. It stays 0 until the tenth cycle with `bit_tick_i`=1. In the following cycle `tx_o` returns to 1 and `cmd_ready_o` becomes 1, and both then hold until reset.
- R8: When `monitor_o`=1, `vec_fetch_i`=1 and `addr_hi_i`=8'hFF, `addr_hi_o` is 8'hFE. In all other cases `addr_hi_o` equals `addr_hi_i`. `remap_o` equals `monitor_o`.
- R9: Asserting reset part-way through the byte intake discards the bytes already counted, so eight fresh bytes are needed.
- R10: In user mode, `tx_o` stays 1 and `cmd_ready_o` stays 0 under any byte or tick traffic, and `wdt_run_o` equals `wdt_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its rising edge latches the mode |
| hv_irq_i | input | 1 | High voltage present on the interrupt pin |
| hv_rst_i | input | 1 | High voltage present on the reset pin |
| pin_cfg_ok_i | input | 1 | Port pins show the monitor entry configuration |
| div_sel_i | input | 1 | Clock divisor select pin |
| vec_hi_i | input | 8 | Reset vector high byte as stored |
| vec_lo_i | input | 8 | Reset vector low byte as stored |
| wdt_en_i | input | 1 | Normal watchdog enable |
| rx_valid_i | input | 1 | One received host byte per cycle high |
| bit_tick_i | input | 1 | Serial bit-period enable |
| vec_fetch_i | input | 1 | CPU is fetching an interrupt or reset vector |
| addr_hi_i | input | 8 | CPU address high byte |
| monitor_o | output | 1 | Latched monitor mode |
| wdt_run_o | output | 1 | Effective watchdog enable |
| div_sel_o | output | 1 | Divisor select in effect |
| tx_o | output | 1 | Serial transmit line, idle high |
| cmd_ready_o | output | 1 | Handshake done, ready for commands |
| remap_o | output | 1 | Vector page redirect active |
| addr_hi_o | output | 8 | Address high byte after redirect |

## Verification
The assertions assume that `rx_valid_i` and `bit_tick_i` are single-cycle strobes with a known level during operation. They also assume that every reset lasts at least one clock edge, so the sampling registers hold defined values at release. The bench holds reset for three clocks with all mode inputs stable, and changes inputs only one time unit after a rising edge. It sends strobes one cycle wide with idle cycles between them, and inverts the mode inputs after release so that any leak from the live pins into the latched mode shows up.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    HS_RST, HS_SEC, HS_BRK, HS_RDY, HS_USER
  } hs_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  function automatic logic vec_is_blank(input logic [7:0] hi, input logic [7:0] lo);
    return (hi == ERASED_BYTE) && (lo == ERASED_BYTE);
  endfunction

  function automatic logic pick_monitor(input logic blank, input logic hv, input logic cfg);
    return blank || (hv && cfg);
  endfunction

  function automatic logic [7:0] remap_page(input logic en, input logic fetch,
                                            input logic [7:0] hi,
                                            input logic [7:0] top_pg,
                                            input logic [7:0] alt_pg);
    return (en && fetch && hi == top_pg) ? alt_pg : hi;
  endfunction
endpackage

// File: rtl/mon_mode_latch.sv
module mon_mode_latch
  import mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hv_irq_i,
  input  logic       hv_rst_i,
  input  logic       pin_cfg_ok_i,
  input  logic       div_sel_i,
  input  logic [7:0] vec_hi_i,
  input  logic [7:0] vec_lo_i,
  input  logic       wdt_en_i,
  output logic       monitor_o,
  output logic       div_sel_o,
  output logic       wdt_run_o
);
  logic smp_hv, smp_cfg, smp_div, smp_blank;

  // Sampling registers track the pins only while reset is low; they freeze on release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_hv    <= hv_irq_i;
      smp_cfg   <= pin_cfg_ok_i;
      smp_div   <= div_sel_i;
      smp_blank <= vec_is_blank(vec_hi_i, vec_lo_i);
    end
  end

  logic hv_entry, blank_entry, wdt_inhibit;
  assign hv_entry    = smp_hv && smp_cfg;
  assign blank_entry = smp_blank;
  assign monitor_o   = pick_monitor(smp_blank, smp_hv, smp_cfg);
  assign div_sel_o   = hv_entry && smp_div;
  assign wdt_inhibit = monitor_o && (blank_entry || hv_irq_i || hv_rst_i);
  assign wdt_run_o   = wdt_en_i && !wdt_inhibit;

  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(monitor_o) && $stable(div_sel_o));
  a_r3_blank_wdt_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank_entry |-> !wdt_run_o);
  a_r5_div_only_hv: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel_o |-> monitor_o && !blank_entry || div_sel_o && hv_entry);
endmodule

// File: rtl/mon_handshake_seq.sv
module mon_handshake_seq
  import mon_pkg::*;
#(
  parameter int SEC_BYTES = 8,
  parameter int BRK_BITS  = 10
)(
  input  logic clk,
  input  logic rst_n,
  input  logic monitor_i,
  input  logic rx_valid_i,
  input  logic bit_tick_i,
  output logic tx_o,
  output logic cmd_ready_o
);
  localparam int MAXC = (SEC_BYTES > BRK_BITS) ? SEC_BYTES : BRK_BITS;
  localparam int CW   = $clog2(MAXC + 1);

  hs_state_t    state;
  logic [CW-1:0] cnt;
  logic sec_done, brk_done;

  assign sec_done = (state == HS_SEC) && rx_valid_i && (cnt == CW'(SEC_BYTES - 1));
  assign brk_done = (state == HS_BRK) && bit_tick_i && (cnt == CW'(BRK_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_RST;
      cnt   <= '0;
    end else begin
      unique case (state)
        HS_RST: begin
          state <= monitor_i ? HS_SEC : HS_USER;
          cnt   <= '0;
        end
        HS_SEC: if (rx_valid_i) begin
          if (sec_done) begin state <= HS_BRK; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        HS_BRK: if (bit_tick_i) begin
          if (brk_done) begin state <= HS_RDY; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tx_o        = (state != HS_BRK);
  assign cmd_ready_o = (state == HS_RDY);

  a_r7_break_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_o) |-> $past(rx_valid_i) && monitor_i);
  a_r7_ready_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready_o) |-> $past(bit_tick_i) && $past(!tx_o));
  a_r10_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !monitor_i |-> tx_o && !cmd_ready_o);
  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |=> cmd_ready_o);
endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap
  import mon_pkg::*;
#(
  parameter logic [7:0] TOP_PAGE = 8'hFF,
  parameter logic [7:0] ALT_PAGE = 8'hFE
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       monitor_i,
  input  logic       vec_fetch_i,
  input  logic [7:0] addr_hi_i,
  output logic       remap_o,
  output logic [7:0] addr_hi_o
);
  assign remap_o   = monitor_i;
  assign addr_hi_o = remap_page(monitor_i, vec_fetch_i, addr_hi_i, TOP_PAGE, ALT_PAGE);

  a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_i && vec_fetch_i && addr_hi_i == TOP_PAGE |-> addr_hi_o == ALT_PAGE);
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !monitor_i |-> addr_hi_o == addr_hi_i);
endmodule

// File: rtl/monitor_entry_ctrl.sv
module monitor_entry_ctrl #(
  parameter int         SEC_BYTES = 8,
  parameter int         BRK_BITS  = 10,
  parameter logic [7:0] TOP_PAGE  = 8'hFF,
  parameter logic [7:0] ALT_PAGE  = 8'hFE
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hv_irq_i,
  input  logic       hv_rst_i,
  input  logic       pin_cfg_ok_i,
  input  logic       div_sel_i,
  input  logic [7:0] vec_hi_i,
  input  logic [7:0] vec_lo_i,
  input  logic       wdt_en_i,
  input  logic       rx_valid_i,
  input  logic       bit_tick_i,
  input  logic       vec_fetch_i,
  input  logic [7:0] addr_hi_i,
  output logic       monitor_o,
  output logic       wdt_run_o,
  output logic       div_sel_o,
  output logic       tx_o,
  output logic       cmd_ready_o,
  output logic       remap_o,
  output logic [7:0] addr_hi_o
);
  logic monitor;

  mon_mode_latch u_latch (
    .clk(clk), .rst_n(rst_n), .hv_irq_i(hv_irq_i), .hv_rst_i(hv_rst_i),
    .pin_cfg_ok_i(pin_cfg_ok_i), .div_sel_i(div_sel_i),
    .vec_hi_i(vec_hi_i), .vec_lo_i(vec_lo_i), .wdt_en_i(wdt_en_i),
    .monitor_o(monitor), .div_sel_o(div_sel_o), .wdt_run_o(wdt_run_o)
  );

  mon_handshake_seq #(.SEC_BYTES(SEC_BYTES), .BRK_BITS(BRK_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .monitor_i(monitor), .rx_valid_i(rx_valid_i),
    .bit_tick_i(bit_tick_i), .tx_o(tx_o), .cmd_ready_o(cmd_ready_o)
  );

  mon_vec_remap #(.TOP_PAGE(TOP_PAGE), .ALT_PAGE(ALT_PAGE)) u_remap (
    .clk(clk), .rst_n(rst_n), .monitor_i(monitor), .vec_fetch_i(vec_fetch_i),
    .addr_hi_i(addr_hi_i), .remap_o(remap_o), .addr_hi_o(addr_hi_o)
  );

  assign monitor_o = monitor;
endmodule

// File: tb/sim_monitor_entry_ctrl.sv
`timescale 1ns/1ps
module sim_monitor_entry_ctrl;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, hv_irq, hv_rst, cfg_ok, div_sel, wdt_en, rx_valid, bit_tick, vec_fetch;
  logic [7:0] vec_hi, vec_lo, addr_in, addr_out;
  logic monitor, wdt_run, div_out, tx, ready, remap;

  monitor_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hv_irq_i(hv_irq), .hv_rst_i(hv_rst),
    .pin_cfg_ok_i(cfg_ok), .div_sel_i(div_sel), .vec_hi_i(vec_hi), .vec_lo_i(vec_lo),
    .wdt_en_i(wdt_en), .rx_valid_i(rx_valid), .bit_tick_i(bit_tick),
    .vec_fetch_i(vec_fetch), .addr_hi_i(addr_in), .monitor_o(monitor),
    .wdt_run_o(wdt_run), .div_sel_o(div_out), .tx_o(tx), .cmd_ready_o(ready),
    .remap_o(remap), .addr_hi_o(addr_out)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  function automatic logic [15:0] vec_of(input int s);
    case (s)
      0: return 16'hFFFF;
      1: return 16'hFF00;
      2: return 16'h00FF;
      default: return 16'h1234;
    endcase
  endfunction

  task automatic apply_reset(input int c);
    rst_n = 0;
    hv_irq = c[0]; hv_rst = c[1]; cfg_ok = c[2]; div_sel = c[5];
    {vec_hi, vec_lo} = vec_of((c >> 3) & 3);
    cyc(3);
    rst_n = 1;
  endtask

  task automatic send_byte();
    rx_valid = 1; cyc(1); rx_valid = 0; cyc(1);
  endtask

  task automatic send_tick();
    bit_tick = 1; cyc(1); bit_tick = 0; cyc(1);
  endtask

  initial begin
    rst_n = 0; hv_irq = 0; hv_rst = 0; cfg_ok = 0; div_sel = 0; wdt_en = 1;
    rx_valid = 0; bit_tick = 0; vec_fetch = 0; addr_in = 0; vec_hi = 0; vec_lo = 0;
    cyc(2);
    at_neg();
    check(tx === 1'b1 && ready === 1'b0, "R6 reset state", {tx, ready}, 2'b10);

    for (int c = 0; c < 64; c++) begin
      logic blank, exp_mon, hv_ent, exp_div, exp_wdt;
      logic [15:0] v;
      v = vec_of((c >> 3) & 3);
      blank   = (v[15:8] == 8'hFF) && (v[7:0] == 8'hFF);
      hv_ent  = c[0] && c[2];
      exp_mon = blank || hv_ent;
      exp_div = hv_ent && c[5];
      apply_reset(c);
      // flip every mode pin after release
      hv_irq = ~hv_irq; hv_rst = ~hv_rst; cfg_ok = ~cfg_ok; div_sel = ~div_sel;
      vec_hi = ~vec_hi; vec_lo = ~vec_lo;
      cyc(2); at_neg();
      check(monitor === exp_mon, "R2 R1 mode", monitor, exp_mon);
      check(div_out === exp_div, "R5 R1 divisor", div_out, exp_div);
      for (int w = 0; w < 8; w++) begin
        wdt_en = w[0]; hv_irq = w[1]; hv_rst = w[2];
        #1;
        if (!exp_mon) exp_wdt = wdt_en;
        else if (blank) exp_wdt = 1'b0;
        else exp_wdt = wdt_en && !(hv_irq || hv_rst);
        check(wdt_run === exp_wdt,
              !exp_mon ? "R10 wdt" : (blank ? "R3 wdt" : "R4 wdt"), wdt_run, exp_wdt);
      end
      wdt_en = 1;
      for (int a = 0; a < 4; a++) begin
        logic [7:0] exp_a;
        vec_fetch = a[0];
        addr_in = a[1] ? 8'h12 : 8'hFF;
        #1;
        exp_a = (exp_mon && vec_fetch && addr_in == 8'hFF) ? 8'hFE : addr_in;
        check(addr_out === exp_a && remap === exp_mon, "R8 remap", addr_out, exp_a);
      end
      vec_fetch = 0;
      cyc(1);
      for (int b = 0; b < 8; b++) begin
        send_byte();
        if (b < 7) check(tx === 1'b1 && ready === 1'b0, "R6 intake", {tx, ready}, 2'b10);
      end
      if (exp_mon) begin
        check(tx === 1'b0, "R7 break start", tx, 1'b0);
        for (int t = 0; t < 10; t++) begin
          if (t > 0) send_byte(); // ignored during break
          check(tx === 1'b0 && ready === 1'b0, "R7 break held", {tx, ready}, 2'b00);
          send_tick();
        end
        check(tx === 1'b1 && ready === 1'b1, "R7 ready", {tx, ready}, 2'b11);
        send_tick(); send_byte();
        check(tx === 1'b1 && ready === 1'b1, "R7 ready holds", {tx, ready}, 2'b11);
      end else begin
        for (int t = 0; t < 12; t++) send_tick();
        check(tx === 1'b1 && ready === 1'b0, "R10 user quiet", {tx, ready}, 2'b10);
      end
    end

    // R9: reset during intake restarts the count
    apply_reset(0);
    cyc(1);
    for (int b = 0; b < 5; b++) send_byte();
    apply_reset(0);
    cyc(1);
    for (int b = 0; b < 7; b++) send_byte();
    check(tx === 1'b1 && ready === 1'b0, "R9 count cleared", {tx, ready}, 2'b10);
    send_byte();
    check(tx === 1'b0, "R9 eighth fresh byte", tx, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule